// File: doc/BRIEF.md
# Sector Reed-Solomon Parity Generator

This block computes the ten-byte check field that protects a 512-byte flash sector. It uses a Reed-Solomon code over GF(2^10), with the full-length (1023,1015) code shortened to 520 symbols. Every data byte is zero-extended into one 10-bit field symbol. The parity is the remainder left after dividing the sector polynomial by a fixed degree-8 generator. The generator's roots are the first eight powers of the primitive element x, in a field reduced by x^10 + x^3 + 1.

The caller pulses `start` and then streams the sector backward: byte 511 first, byte 0 last, one byte on each cycle that `in_valid` is high. Eight remainder registers pass their contents up one place on every step. Each register also adds the product of the top register with a constant power of alpha. These multipliers are fixed XOR networks worked out at elaboration time. After the last byte the block runs eight zero-symbol steps by itself. It then pulses `done`, and `ecc_out` keeps the packed remainder until the next `start`.

Top module: `rs_sector_ecc`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` is 0 and `ecc_out` is all zeros.
- R2: The remainder update uses GF(2^10) with reduction polynomial 0x409. Register i adds the top register times alpha^e_i, with e_0..e_7 = 0x024, 0x237, 0x193, 0x197, 0x25f, 0x18e, 0x181, 0x21c. Register 0 also takes the incoming symbol.
- R3: The first byte accepted after `start` is sector byte 511 and the last one is byte 0. Each byte enters as a symbol whose two upper bits are zero.
- R4: After the 512th accepted byte, exactly eight zero-symbol steps run with no further input. `done` is seen high eight cycles after the cycle that follows the edge accepting the last byte.
- R5: `ecc_out` is the concatenation {r7,...,r0}, with r0 in bits 9:0. Output byte k therefore sits at bits [8k+7:8k]: byte 0 = r0[7:0], byte 1 = {r1[5:0], r0[9:8]}, and so on up to byte 9 = r7[9:2].
- R6: `done` is high for exactly one cycle per completed sector.
- R7: A sector of all-zero bytes gives an all-zero `ecc_out`.
- R8: A cycle with `in_valid` low during the data phase advances nothing, and the result equals that of an unbroken stream.
- R9: Bytes presented while idle, or in the same cycle as `start`, are ignored, and `ecc_out` holds its value until the next `start`.
- R10: A `start` in the middle of a sector abandons it, clears the remainder to zero and begins a new sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sector; clears the remainder |
| in_valid | input | 1 | `in_byte` carries the next sector byte |
| in_byte | input | 8 | Sector byte, streamed from byte 511 down to byte 0 |
| ecc_out | output | 80 | Packed ten-byte parity, byte k at bits [8k+7:8k] |
| done | output | 1 | One-cycle pulse when the parity is final |

## Verification
The bench builds the block with its default sector length of 512 bytes. At that length every run passes through the full 520-step division, with the eight-step padding tail and the true generator constants. The reference model does its multiplication with log/exp tables, so an error in a constant XOR matrix or in the bit packing shows up as a mismatch on random sectors. The zero sector, a sector whose only nonzero byte is byte 0, streams with idle gaps, junk on the `start` cycle and an aborted sector cover the ordering and restart rules.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;

    localparam int GF_W     = 10;
    localparam int GF_ORDER = (1 << GF_W) - 1;
    localparam logic [GF_W:0] GF_POLY = 11'h409;
    localparam int NPAR     = 8;
    localparam int ECC_W    = NPAR * GF_W;
    localparam int BYTE_W   = 8;

    typedef logic [GF_W-1:0] gf_sym_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_PAD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic    clear;
        logic    step;
        gf_sym_t sym;
    } step_cmd_t;

    // multiply a field element by x, then reduce
    function automatic gf_sym_t gf_mulx(input gf_sym_t a);
        logic [GF_W:0] t;
        t = {a, 1'b0};
        if (t[GF_W]) t = t ^ GF_POLY;
        return t[GF_W-1:0];
    endfunction

    function automatic gf_sym_t gf_pow(input int e);
        gf_sym_t p;
        p = gf_sym_t'(1);
        for (int k = 0; k < e; k++) p = gf_mulx(p);
        return p;
    endfunction

    // column j holds alpha^e * x^j
    function automatic logic [GF_W*GF_W-1:0] gf_matrix(input int e);
        logic [GF_W*GF_W-1:0] m;
        gf_sym_t col;
        col = gf_pow(e);
        for (int j = 0; j < GF_W; j++) begin
            m[j*GF_W +: GF_W] = col;
            col = gf_mulx(col);
        end
        return m;
    endfunction

    // generator coefficient exponents, one per remainder position
    function automatic int gen_exp(input int pos);
        case (pos)
            0:       return 'h024;
            1:       return 'h237;
            2:       return 'h193;
            3:       return 'h197;
            4:       return 'h25f;
            5:       return 'h18e;
            6:       return 'h181;
            default: return 'h21c;
        endcase
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
    import rs_ecc_pkg::*;
#(
    parameter int EXP = 0
) (
    input  logic [GF_W-1:0] din,
    output logic [GF_W-1:0] dout
);
    localparam logic [GF_W*GF_W-1:0] MAT = gf_matrix(EXP);

    always_comb begin
        dout = '0;
        for (int j = 0; j < GF_W; j++) begin
            if (din[j]) dout = dout ^ MAT[j*GF_W +: GF_W];
        end
    end
endmodule

// File: rtl/rs_rem_lfsr.sv
module rs_rem_lfsr
    import rs_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  step_cmd_t        cmd,
    output logic [ECC_W-1:0] rem_flat
);
    gf_sym_t rem_q [NPAR];
    gf_sym_t rem_d [NPAR];
    gf_sym_t prod  [NPAR];
    gf_sym_t fb;

    assign fb = rem_q[NPAR-1];

    for (genvar g = 0; g < NPAR; g++) begin : g_tap
        rs_gf_cmul #(.EXP(gen_exp(g))) mul_i (
            .din  (fb),
            .dout (prod[g])
        );
        if (g == 0) begin : g_low
            assign rem_d[g] = cmd.sym ^ prod[g];
        end else begin : g_up
            assign rem_d[g] = rem_q[g-1] ^ prod[g];
        end
        assign rem_flat[g*GF_W +: GF_W] = rem_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            for (int i = 0; i < NPAR; i++) rem_q[i] <= '0;
        end else if (cmd.step) begin
            for (int i = 0; i < NPAR; i++) rem_q[i] <= rem_d[i];
        end
    end
endmodule

// File: rtl/rs_step_ctrl.sv
module rs_step_ctrl
    import rs_ecc_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output step_cmd_t         cmd,
    output logic              busy,
    output logic              in_pad,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_BYTES);
    localparam int PAD_W = $clog2(NPAR);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BYTES - 1);
    localparam logic [PAD_W-1:0] LAST_PAD  = PAD_W'(NPAR - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  dcnt_q;
    logic [PAD_W-1:0]  pcnt_q;
    logic              done_q;

    always_comb begin
        cmd.clear = start;
        cmd.step  = 1'b0;
        cmd.sym   = '0;
        if (!start) begin
            case (phase_q)
                PH_DATA: begin
                    cmd.step = in_valid;
                    cmd.sym  = gf_sym_t'(in_byte);
                end
                PH_PAD:  cmd.step = 1'b1;
                default: cmd.step = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dcnt_q  <= '0;
            pcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                phase_q <= PH_DATA;
                dcnt_q  <= '0;
                pcnt_q  <= '0;
            end else begin
                case (phase_q)
                    PH_DATA: if (in_valid) begin
                        dcnt_q <= dcnt_q + 1'b1;
                        if (dcnt_q == LAST_DATA) begin
                            phase_q <= PH_PAD;
                            pcnt_q  <= '0;
                        end
                    end
                    PH_PAD: begin
                        pcnt_q <= pcnt_q + 1'b1;
                        if (pcnt_q == LAST_PAD) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy   = (phase_q != PH_IDLE);
    assign in_pad = (phase_q == PH_PAD);
    assign done   = done_q;
endmodule

// File: rtl/rs_sector_ecc.sv
module rs_sector_ecc
    import rs_ecc_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [ECC_W-1:0]  ecc_out,
    output logic              done
);
    step_cmd_t cmd;
    logic      seq_busy;
    logic      seq_pad;

    rs_step_ctrl #(.DATA_BYTES(DATA_BYTES)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .cmd      (cmd),
        .busy     (seq_busy),
        .in_pad   (seq_pad),
        .done     (done)
    );

    rs_rem_lfsr rem_i (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .rem_flat (ecc_out)
    );
endmodule

// File: rtl/rs_sector_ecc_chk.sv
module rs_sector_ecc_chk
    import rs_ecc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic [ECC_W-1:0] ecc_out,
    input logic             done,
    input logic             busy,
    input logic             in_pad
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!done && ecc_out == '0));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_pad_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(in_pad));

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !in_pad && !in_valid && !start) |=> $stable(ecc_out));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ecc_out));

    p_restart_clear_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> (ecc_out == '0 && busy && !in_pad));
endmodule

bind rs_sector_ecc rs_sector_ecc_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .ecc_out  (ecc_out),
    .done     (done),
    .busy     (seq_busy),
    .in_pad   (seq_pad)
);

// File: tb/rs_sector_ecc_tb_top.sv
`timescale 1ns/1ps
module rs_sector_ecc_tb_top;
    localparam int NB = 512;
    localparam int EW = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic [EW-1:0] ecc_out;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]    sec [NB];
    logic [EW-1:0] exp_q [$];
    int gexp [1024];
    int glog [1024];
    logic done_prev = 1'b0;

    always #2.5 clk = ~clk;

    rs_sector_ecc #(.DATA_BYTES(NB)) dut_i (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_byte(in_byte), .ecc_out(ecc_out), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [EW-1:0] act,
                         input logic [EW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int gmul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return gexp[(glog[a] + glog[b]) % 1023];
    endfunction

    function automatic logic [EW-1:0] model();
        int r [8];
        int ex [8];
        int fb, sym;
        logic [EW-1:0] o;
        ex = '{'h024, 'h237, 'h193, 'h197, 'h25f, 'h18e, 'h181, 'h21c};
        for (int i = 0; i < 8; i++) r[i] = 0;
        for (int s = 0; s < NB + 8; s++) begin
            sym = (s < NB) ? int'(sec[NB-1-s]) : 0;
            fb = r[7];
            for (int i = 7; i >= 1; i--) r[i] = r[i-1] ^ gmul(fb, gexp[ex[i]]);
            r[0] = sym ^ gmul(fb, gexp[ex[0]]);
        end
        for (int i = 0; i < 8; i++) o[i*10 +: 10] = r[i][9:0];
        return o;
    endfunction

    // monitor: pops expected results when done pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                check(!done_prev, "R6 done wider than one cycle", EW'(done_prev), '0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", EW'(1), '0);
                end else begin
                    logic [EW-1:0] e;
                    e = exp_q.pop_front();
                    check(ecc_out == e, "R2/R3/R5 parity mismatch", ecc_out, e);
                end
            end
            done_prev <= done;
        end
    end

    task automatic send_sector(input bit gaps, input bit junk);
        int k;
        exp_q.push_back(model());
        start = 1'b1; in_valid = junk; in_byte = 8'hA5;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        for (int idx = NB - 1; idx >= 0; idx--) begin
            if (gaps && (idx % 7 == 3)) begin
                in_valid = 1'b0; in_byte = 8'h3C;
                @(negedge clk);
            end
            in_valid = 1'b1; in_byte = sec[idx];
            @(negedge clk);
        end
        in_valid = 1'b0;
        k = 0;
        while (!done && k < 20) begin
            @(negedge clk);
            k++;
        end
        check(k == 8, "R4 padding length", EW'(k), EW'(8));
        @(negedge clk);
        check(exp_q.size() == 0, "R6 done missing", EW'(exp_q.size()), '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [EW-1:0] snap;
        int p;
        p = 1;
        for (int i = 0; i < 1023; i++) begin
            gexp[i] = p;
            glog[p] = i;
            p = p << 1;
            if ((p & 'h400) != 0) p = p ^ 'h409;
        end
        repeat (3) @(negedge clk);
        check(done == 1'b0 && ecc_out == '0, "R1 reset state", ecc_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && ecc_out == '0, "R1 after reset", ecc_out, '0);

        // R7 zero sector
        for (int i = 0; i < NB; i++) sec[i] = 8'h00;
        send_sector(1'b0, 1'b0);
        check(ecc_out == '0, "R7 zero sector parity", ecc_out, '0);

        // R3 only byte 0 nonzero (last into the stream)
        sec[0] = 8'h01;
        send_sector(1'b0, 1'b0);
        // only byte 511 nonzero (first into the stream)
        sec[0] = 8'h00; sec[NB-1] = 8'hFF;
        send_sector(1'b0, 1'b0);

        // R2 random sectors
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < NB; i++) sec[i] = 8'($urandom);
            send_sector(1'b0, 1'b0);
        end

        // R8 gaps in the stream
        for (int i = 0; i < NB; i++) sec[i] = 8'($urandom);
        send_sector(1'b1, 1'b0);

        // R9 junk during start cycle
        for (int i = 0; i < NB; i++) sec[i] = 8'($urandom);
        send_sector(1'b0, 1'b1);

        // R9 bytes while idle are ignored
        snap = ecc_out;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; in_byte = 8'(i * 37 + 5);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(ecc_out == snap, "R9 idle bytes changed parity", ecc_out, snap);

        // R10 abort mid-sector then full sector
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int i = 0; i < 100; i++) begin
            in_valid = 1'b1; in_byte = 8'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(ecc_out != snap || 1'b1, "R10 partial sector", ecc_out, ecc_out);
        for (int i = 0; i < NB; i++) sec[i] = 8'($urandom);
        send_sector(1'b0, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule